// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers single-cycle event pulses from the rest of the device into a word of sticky status flags. A host-written mask word selects which flags may pull an active-low interrupt line. The top mask bit acts as a global enable. A host read of the status word captures the flags together with the current line state, and clears every flag at the start of the read. Anything not yet serviced therefore raises a fresh interrupt only when a new event arrives.

The host bus decoder sits outside the block. It delivers mask writes as a write strobe with data. It delivers the command/address phase of a status read as a strobe that may stay high for several cycles. A two-state read tracker issues exactly one clear for each read. State `RD_IDLE` waits for the strobe. The transition `RD_IDLE -> RD_HELD` fires on the first strobe cycle: it captures the status word and clears the flags. `RD_HELD` persists while the strobe stays high. The transition `RD_HELD -> RD_IDLE` fires when the strobe drops. `RD_IDLE` also persists while no strobe is seen.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset all flags and all mask bits are zero, `irq_n_o` is 1 and `stat_rdata_o` is 0.
- R2: A pulse on `evt_i[i]` (i in 0..14) sets flag i at that clock edge. The flag stays set until a status read clears it. Flag i is returned in bit i of the status word.
- R3: In every cycle, `irq_n_o` is 0 exactly when mask bit 15 is 1 and some flag i has mask bit i set. It reflects flags and mask as updated at the previous edge.
- R4: While mask bit 15 is 0, `irq_n_o` stays 1 whatever the flags and the other mask bits are.
- R5: Writing a mask that enables a flag already set drives `irq_n_o` low in the cycle after the write edge.
- R6: On the first cycle of a read strobe, `stat_rdata_o` captures the status word. Bits 14:0 are the flags as they stood before that edge. Bit 15 is 1 if `irq_n_o` was low in that cycle.
- R7: The same edge clears every flag, so `irq_n_o` returns high unless a new event arrives.
- R8: An event that arrives at the clearing edge is kept set after the clear. It is absent from the captured word.
- R9: A strobe held high for several cycles clears only once. Events that arrive during the later strobe cycles stay set.
- R10: `stat_rdata_o` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 15 | Event pulses, one per flag |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 16 | Mask value; bit 15 is the global enable |
| stat_rd_i | input | 1 | Status read strobe (command/address phase) |
| stat_rdata_o | output | 16 | Status word captured at the last read |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
Every result is due one edge after its cause. A flag set by an event, or a new mask, shows on `irq_n_o` after that single edge. The word captured at the first strobe cycle appears on `stat_rdata_o` after one edge, and the line goes high after the same edge. The bench drives inputs on falling edges and compares both outputs with its reference model on every falling edge. At that point exactly one rising edge has passed since the inputs were applied. Its directed checks likewise sample one falling edge after the stimulus cycle ends.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/irqc_rd_fsm.sv
module irqc_rd_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    output logic clr_o
);
    rd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_i)  state_d = RD_HELD;
            RD_HELD: if (!rd_i) state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        clr_o = 1'b0;
        unique case (state_q)
            RD_IDLE: clr_o = rd_i;
            RD_HELD: clr_o = 1'b0;
        endcase
    end

    AST_ONE_CLEAR_PER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o && rd_i) |=> !clr_o); // R9
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags_o[i] <= 1'b0;
            else if (evt_i[i]) flags_o[i] <= 1'b1;
            else if (clr_i)    flags_o[i] <= 1'b0;
        end
    end

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i))); // R8
    AST_CLEAR_LEAVES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flags_o == $past(evt_i))); // R7
endmodule

// File: rtl/irqc_irq_combine.sv
module irqc_irq_combine #(
    parameter int N = 15
) (
    input  logic [N-1:0] flags_i,
    input  logic [N:0]   mask_i,
    output logic         req_o
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = flags_i[i] & mask_i[i];
    end

    assign req_o = mask_i[N] & (|hit);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
    parameter int EVT_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_W-1:0]   evt_i,
    input  logic               mask_wr_i,
    input  logic [EVT_W:0]     mask_wdata_i,
    input  logic               stat_rd_i,
    output logic [EVT_W:0]     stat_rdata_o,
    output logic               irq_n_o
);
    localparam int WORD_W = EVT_W + 1;
    localparam int GEN_B  = EVT_W;

    logic [EVT_W-1:0]  flags;
    logic [WORD_W-1:0] mask_q;
    logic              clr;
    logic              req;

    irqc_rd_fsm u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_i  (stat_rd_i),
        .clr_o (clr)
    );

    irqc_flags #(.N(EVT_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .evt_i   (evt_i),
        .flags_o (flags)
    );

    irqc_irq_combine #(.N(EVT_W)) u_comb (
        .flags_i (flags),
        .mask_i  (mask_q),
        .req_o   (req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= mask_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   stat_rdata_o <= '0;
        else if (clr) stat_rdata_o <= {req, flags};
    end

    assign irq_n_o = ~req;

    AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[GEN_B] |-> irq_n_o); // R4
    AST_NO_HIT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask_q[EVT_W-1:0]) == '0) |-> irq_n_o); // R3
    AST_BIT15_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stat_rdata_o[GEN_B] == !$past(irq_n_o))); // R6
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(stat_rdata_o)); // R10
endmodule

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/100ps
module sim_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] evt = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd = 1'b0;
    logic [15:0] rdata;
    logic        irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .mask_wr_i(wr),
        .mask_wdata_i(wdata), .stat_rd_i(rd), .stat_rdata_o(rdata), .irq_n_o(irq_n)
    );

    // behavioural reference model
    bit [14:0] m_flags;
    bit [15:0] m_mask, m_rd;
    bit        m_prev;

    function automatic bit m_line();
        bit any = 0;
        for (int i = 0; i < 15; i++) if (m_flags[i] && m_mask[i]) any = 1;
        return m_mask[15] && any;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = '0; m_mask = '0; m_rd = '0; m_prev = 0;
        end else begin
            if (rd && !m_prev) begin
                m_rd = {m_line(), m_flags};
                m_flags = evt;
            end else begin
                m_flags = m_flags | evt;
            end
            if (wr) m_mask = wdata;
            m_prev = rd;
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        chk("R3 line", {15'd0, irq_n}, {15'd0, !m_line()});
        chk("R6 rdata", rdata, m_rd);
    end

    task automatic tick(logic [14:0] e, logic w, logic [15:0] d, logic r);
        @(negedge clk);
        evt = e; wr = w; wdata = d; rd = r;
    endtask

    task automatic idle();
        tick('0, 0, '0, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk("R1 irq", {15'd0, irq_n}, 16'd1);
        chk("R1 rdata", rdata, 16'h0000);

        tick(15'h0008, 0, '0, 0); idle();
        chk("R4 masked", {15'd0, irq_n}, 16'd1);
        tick('0, 0, '0, 1); idle();
        chk("R2 flag3", rdata, 16'h0008);
        chk("R7 line high", {15'd0, irq_n}, 16'd1);

        tick('0, 1, 16'h8008, 0);
        tick(15'h0008, 0, '0, 0); idle();
        chk("R3 asserted", {15'd0, irq_n}, 16'd0);
        tick('0, 0, '0, 1); idle();
        chk("R6 bit15", rdata, 16'h8008);
        chk("R7 cleared", {15'd0, irq_n}, 16'd1);

        tick('0, 1, 16'h0010, 0);
        tick(15'h0010, 0, '0, 0); idle();
        chk("R4 global off", {15'd0, irq_n}, 16'd1);
        tick('0, 1, 16'h8010, 0); idle();
        chk("R5 late enable", {15'd0, irq_n}, 16'd0);
        tick('0, 0, '0, 1); idle();
        chk("R6 word", rdata, 16'h8010);

        tick('0, 1, 16'h8080, 0);
        tick(15'h0002, 0, '0, 0); idle();
        chk("R3 unmasked flag", {15'd0, irq_n}, 16'd1);
        tick(15'h0080, 0, '0, 1); idle();
        chk("R8 captured", rdata, 16'h0002);
        chk("R8 kept", {15'd0, irq_n}, 16'd0);
        tick('0, 0, '0, 1); idle();
        chk("R8 next read", rdata, 16'h8080);

        tick('0, 0, '0, 1);
        tick(15'h0200, 0, '0, 1);
        tick('0, 0, '0, 1); idle();
        tick('0, 0, '0, 1); idle();
        chk("R9 held strobe", rdata, 16'h0200);

        tick(15'h0080, 0, '0, 0);
        tick(15'h0001, 0, '0, 0); idle();
        chk("R10 hold", rdata, 16'h0200);
        chk("R3 again", {15'd0, irq_n}, 16'd0);

        for (int k = 0; k < 400; k++) begin
            tick(($urandom % 4 == 0) ? 15'($urandom) : 15'd0,
                 ($urandom % 8 == 0), 16'($urandom), ($urandom % 5 == 0));
        end
        idle(); idle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule